// File: doc/BRIEF.md
# Sine/Cosine Phase-to-Amplitude Converter (Coarse Table plus Fine Rotation)

This block turns a 19-bit phase word into a signed 16-bit sine sample and a signed 16-bit cosine sample. It accepts a new phase on every clock and returns one result per clock, with a valid flag, after a fixed pipeline delay. It is meant to sit after the truncation stage of a numerically controlled oscillator and in front of whatever consumes the waveform samples.

The three top phase bits pick one of eight octants. In odd octants the remaining 16 bits are bit-complemented, so every sample maps into the first eighth of a period. The next seven bits index a 128-entry table of cosine/sine pairs. The table is computed when the design is elaborated, and each entry sits at a point centred in its slice. The low nine bits form three 3-bit groups. Each group value g becomes a signed digit g-4 and drives one small rotation step of that digit times the group's weight. The steps run from the most significant group down. Octant symmetry then swaps and negates the first-octant pair to give the full-cycle result.

Top module: `ddsPhaseAmp`

## Requirements
- R1: `outValid` sampled at any rising edge equals `inValid` sampled six rising edges earlier, so a phase accepted on one edge appears on the outputs right after the fifth edge that follows it.
- R2: The phase word p stands for the angle 2*pi*p/2^19. On every valid output, `sinOut` is within 3 LSB of round(32767*sin(angle)), in two's complement.
- R3: On every valid output, `cosOut` is within 3 LSB of round(32767*cos(angle)).
- R4: The four axis phases 0x00000, 0x20000, 0x40000 and 0x60000 give (sin, cos) of exactly (0, 32767), (32767, 0), (0, -32767) and (-32767, 0).
- R5: Neither output ever takes the value -32768; results are clamped to the range -32767..32767.
- R6: Phases can arrive back-to-back or with idle gaps. Each accepted phase yields exactly one output, and the outputs come out in the order the phases were accepted.
- R7: While `outValid` is low, `sinOut` and `cosOut` keep their previous values.
- R8: During reset `outValid` is 0 and both outputs are 0.
- R9: Half-period symmetry is exact. For every p, sin(p+2^18) = -sin(p) and cos(p+2^18) = -cos(p), with the phase taken modulo 2^19.
- R10: Quarter-period symmetry is exact. For every p, sin(p+2^17) = cos(p) and cos(p+2^17) = -sin(p), with the phase taken modulo 2^19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Phase word on `phaseIn` is to be converted this cycle |
| phaseIn | input | 19 | Phase word: octant in bits 18:16, table index in 15:9, fine groups in 8:0 |
| outValid | output | 1 | Output samples are new this cycle |
| sinOut | output | 16 | Signed sine sample |
| cosOut | output | 16 | Signed cosine sample |

## Verification
The properties take for granted that `inValid` is held low throughout reset. They also take for granted that `inValid` and `phaseIn` carry known values on every edge after reset is released, so the six-edge history used for the latency and axis checks only ever sees real samples. The bench holds `inValid` low until reset is released and then changes inputs only on falling edges. It mixes bursts, gaps, octant-boundary phases and symmetric triples of phases, so that every octant and every fine digit is reached within those assumptions.

// File: rtl/ddsPhaseAmpPkg.sv
package ddsPhaseAmpPkg;

  // number of 3-bit fine-rotation groups (one pipeline stage each)
  localparam int GRP_CNT = 3;
  // pi in Q30 fixed point
  localparam longint PI_Q30 = 64'sd3373259426;

  // per-stage load strobes from control to datapath
  typedef struct packed {
    logic               fold;
    logic               rom;
    logic [GRP_CNT-1:0] rot;
    logic               out;
  } stageStrobeT;

  // Taylor series for sin or cos of a Q30 angle below pi/4
  function automatic longint taylorQ30(input longint th, input bit wantSin);
    longint x2, t, s;
    x2 = (th * th) >>> 30;
    t  = wantSin ? th : (64'sd1 <<< 30);
    s  = t;
    for (int n = 1; n < 8; n++) begin
      longint a;
      a = wantSin ? longint'(2 * n) : longint'(2 * n - 1);
      t = -(((t * x2) >>> 30) / (a * (a + 1)));
      s = s + t;
    end
    return s;
  endfunction

  // coarse entry idx, evaluated at the centre point of the fine digit range
  function automatic int coarseVal(input int idx, input int resW, input int lowW,
                                   input int grpW, input longint amp, input bit wantSin);
    longint pos, th, v;
    pos = longint'(idx) <<< lowW;
    for (int j = 0; j < GRP_CNT; j++) pos = pos + (64'sd1 <<< (grpW * j + grpW - 1));
    th = (pos * PI_Q30) >>> (resW + 2);
    v  = taylorQ30(th, wantSin);
    return int'((v * amp + (64'sd1 <<< 29)) >>> 30);
  endfunction

  // rotation coefficient for one residual-phase weight, scaled by 2^cfW
  function automatic longint rotCoef(input int weight, input int resW, input int cfW);
    int sh;
    sh = 32 + resW - cfW;
    return (longint'(weight) * PI_Q30 + (64'sd1 <<< (sh - 1))) >>> sh;
  endfunction

endpackage

// File: rtl/ddsPhaseAmpCtrl.sv
module ddsPhaseAmpCtrl
  import ddsPhaseAmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output stageStrobeT strobe,
  output logic        outValid
);
  localparam int LAT = GRP_CNT + 3;

  logic [LAT-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.fold = inValid;
    strobe.rom  = vPipe[0];
    strobe.rot  = vPipe[GRP_CNT:1];
    strobe.out  = vPipe[GRP_CNT+1];
  end

  assign outValid = vPipe[LAT-1];
endmodule

// File: rtl/ddsPhaseAmpDatapath.sv
module ddsPhaseAmpDatapath
  import ddsPhaseAmpPkg::*;
#(
  parameter int PHASE_W = 19,
  parameter int ADDR_W  = 7,
  parameter int OUT_W   = 16,
  parameter int GUARD_W = 3,
  parameter int CF_W    = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageStrobeT             strobe,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);
  localparam int RES_W = PHASE_W - 3;
  localparam int LOW_W = RES_W - ADDR_W;
  localparam int GRP_W = LOW_W / GRP_CNT;
  localparam int IW    = OUT_W + GUARD_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXO  = (1 << (OUT_W - 1)) - 1;
  localparam int LAST  = GRP_CNT + 1;
  localparam longint AMP = longint'(MAXO) <<< GUARD_W;
  localparam logic signed [IW-1:0] AMP_I  = IW'(AMP);
  localparam logic signed [IW-1:0] MAX_I  = IW'(MAXO);
  localparam logic signed [IW-1:0] HALF_I = IW'(1 << (GUARD_W - 1));

  // fold stage
  logic [RES_W-1:0]  resid;
  logic [ADDR_W-1:0] addrR;
  assign resid = phaseIn[RES_W] ? ~phaseIn[RES_W-1:0] : phaseIn[RES_W-1:0];

  // side-band pipeline: index 0 = fold, 1 = table, j+2 = rotation j
  logic [2:0]       octP  [0:LAST];
  logic             zeroP [0:LAST];
  logic [LOW_W-1:0] lowP  [0:GRP_CNT];

  // data pipeline: index 0 = table output, j+1 = after rotation j
  logic signed [IW-1:0] xP  [0:GRP_CNT];
  logic signed [IW-1:0] yP  [0:GRP_CNT];
  logic signed [IW-1:0] xNx [0:GRP_CNT-1];
  logic signed [IW-1:0] yNx [0:GRP_CNT-1];

  // coarse table, one eighth of a period, computed at elaboration
  logic signed [IW-1:0] cosTab [DEPTH];
  logic signed [IW-1:0] sinTab [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int CV = coarseVal(k, RES_W, LOW_W, GRP_W, AMP, 1'b0);
    localparam int SV = coarseVal(k, RES_W, LOW_W, GRP_W, AMP, 1'b1);
    assign cosTab[k] = IW'(CV);
    assign sinTab[k] = IW'(SV);
  end

  // fine rotations, most significant group first, digit = group - 4
  for (genvar j = 0; j < GRP_CNT; j++) begin : g_rot
    localparam int GI = GRP_CNT - 1 - j;
    localparam longint COEF = rotCoef(1 << (GRP_W * GI), RES_W, CF_W);
    logic signed [GRP_W:0] dig;
    logic signed [63:0]    dx, dy;
    assign dig = $signed({1'b0, lowP[j+1][GI*GRP_W +: GRP_W]})
               - $signed((GRP_W+1)'(1 << (GRP_W - 1)));
    assign dx = (64'(xP[j]) * 64'(dig) * COEF) >>> CF_W;
    assign dy = (64'(yP[j]) * 64'(dig) * COEF) >>> CF_W;
    assign xNx[j] = xP[j] - IW'(dy);
    assign yNx[j] = yP[j] + IW'(dx);
  end

  always_ff @(posedge clk) begin
    if (strobe.fold) begin
      octP[0]  <= phaseIn[PHASE_W-1 -: 3];
      addrR    <= resid[RES_W-1 -: ADDR_W];
      lowP[0]  <= resid[LOW_W-1:0];
      zeroP[0] <= (phaseIn[RES_W:0] == '0);
    end
    if (strobe.rom) begin
      xP[0]    <= cosTab[addrR];
      yP[0]    <= sinTab[addrR];
      lowP[1]  <= lowP[0];
      octP[1]  <= octP[0];
      zeroP[1] <= zeroP[0];
    end
    for (int j = 0; j < GRP_CNT; j++) begin
      if (strobe.rot[j]) begin
        xP[j+1]    <= xNx[j];
        yP[j+1]    <= yNx[j];
        octP[j+2]  <= octP[j+1];
        zeroP[j+2] <= zeroP[j+1];
        if (j < GRP_CNT - 1) lowP[j+2] <= lowP[j+1];
      end
    end
  end

  function automatic logic signed [OUT_W-1:0] rndSat(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] r;
    r = (v + HALF_I) >>> GUARD_W;
    if (r > MAX_I)       r = MAX_I;
    else if (r < -MAX_I) r = -MAX_I;
    return OUT_W'(r);
  endfunction

  // octant mapping
  logic [2:0]             oct;
  logic signed [IW-1:0]   cFirst, sFirst;
  logic signed [OUT_W-1:0] cR, sR, sinM, cosM;
  always_comb begin
    oct    = octP[LAST];
    cFirst = zeroP[LAST] ? AMP_I : xP[GRP_CNT];
    sFirst = zeroP[LAST] ? '0    : yP[GRP_CNT];
    cR     = rndSat(cFirst);
    sR     = rndSat(sFirst);
    sinM   = (oct[0] ^ oct[1]) ? cR : sR;
    cosM   = (oct[0] ^ oct[1]) ? sR : cR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (strobe.out) begin
      sinOut <= oct[2] ? -sinM : sinM;
      cosOut <= (oct[2] ^ oct[1]) ? -cosM : cosM;
    end
  end
endmodule

// File: rtl/ddsPhaseAmp.sv
module ddsPhaseAmp
  import ddsPhaseAmpPkg::*;
#(
  parameter int PHASE_W = 19,
  parameter int ADDR_W  = 7,
  parameter int OUT_W   = 16,
  parameter int GUARD_W = 3,
  parameter int CF_W    = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);
  stageStrobeT strobe;

  ddsPhaseAmpCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ddsPhaseAmpDatapath #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .OUT_W   (OUT_W),
    .GUARD_W (GUARD_W),
    .CF_W    (CF_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .phaseIn (phaseIn),
    .sinOut  (sinOut),
    .cosOut  (cosOut)
  );
endmodule

// File: rtl/ddsPhaseAmpChk.sv
module ddsPhaseAmpChk #(
  parameter int PHASE_W = 19,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [PHASE_W-1:0]      phaseIn,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] sinOut,
  input logic signed [OUT_W-1:0] cosOut
);
  localparam logic signed [OUT_W-1:0] MAXV = OUT_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  // edges seen since reset release, saturating
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 7)  sinceRst <= sinceRst + 3'd1;
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 7) |-> (outValid == $past(inValid, 6)));

  // R4
  axis_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst == 7) && outValid && $past(inValid && (phaseIn == '0), 6))
      |-> ((sinOut == '0) && (cosOut == MAXV)));

  // R5
  no_neg_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((sinOut != MINV) && (cosOut != MINV)));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst != 0) && !outValid) |-> ($stable(sinOut) && $stable(cosOut)));
endmodule

bind ddsPhaseAmp ddsPhaseAmpChk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .phaseIn  (phaseIn),
  .outValid (outValid),
  .sinOut   (sinOut),
  .cosOut   (cosOut)
);

// File: tb/ddsPhaseAmp_tb.sv
module ddsPhaseAmp_tb;
  localparam int PW   = 19;
  localparam int FULL = 1 << PW;
  localparam int MAXO = 32767;
  localparam int TOL  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [PW-1:0] phaseIn = '0;
  logic outValid;
  logic signed [15:0] sinOut, cosOut;

  always #10 clk = ~clk;

  ddsPhaseAmp u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .phaseIn(phaseIn),
    .outValid(outValid), .sinOut(sinOut), .cosOut(cosOut)
  );

  typedef struct { int ph; int cyc; } itemT;
  itemT expQ[$];
  int sinRes[int];
  int cosRes[int];
  int symBase[$];
  int checks = 0, fails = 0, cyc = 0, sent = 0, got = 0;
  int lastSin = 0, lastCos = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int refVal(input int p, input bit wantSin);
    real a;
    a = 2.0 * 3.14159265358979 * real'(p) / real'(FULL);
    return wantSin ? int'($floor(real'(MAXO) * $sin(a) + 0.5))
                   : int'($floor(real'(MAXO) * $cos(a) + 0.5));
  endfunction

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic send(input int p);
    itemT it;
    @(negedge clk);
    inValid = 1'b1;
    phaseIn = PW'(p);
    it.ph = p % FULL;
    it.cyc = cyc;
    expQ.push_back(it);
    sent++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    itemT it;
    int es, ec;
    if (rstN && !done) begin
      if (outValid) begin
        got++;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "output with no pending phase", got, sent);
        end else begin
          it = expQ.pop_front();
          es = refVal(it.ph, 1'b1);
          ec = refVal(it.ph, 1'b0);
          check(cyc == it.cyc + 6, "R1", "latency", cyc - it.cyc, 6);
          check(absI(int'(sinOut) - es) <= TOL, "R2", "sine", int'(sinOut), es);
          check(absI(int'(cosOut) - ec) <= TOL, "R3", "cosine", int'(cosOut), ec);
          check(int'(sinOut) != -32768 && int'(cosOut) != -32768, "R5",
                "full-scale negative", int'(sinOut), -32767);
          if ((it.ph % (FULL / 4)) == 0) begin
            check(int'(sinOut) == es, "R4", "axis sine", int'(sinOut), es);
            check(int'(cosOut) == ec, "R4", "axis cosine", int'(cosOut), ec);
          end
          sinRes[it.ph] = int'(sinOut);
          cosRes[it.ph] = int'(cosOut);
        end
        lastSin = int'(sinOut);
        lastCos = int'(cosOut);
      end else begin
        check(int'(sinOut) == lastSin && int'(cosOut) == lastCos, "R7",
              "hold while idle", int'(sinOut), lastSin);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    check(sinOut == 0 && cosOut == 0, "R8", "outputs in reset", int'(sinOut), 0);
    rstN = 1'b1;
    idle(2);

    // R4 axis points, back-to-back (R6)
    send(0); send(FULL / 4); send(FULL / 2); send(3 * FULL / 4);
    idle(3);

    // octant edges and extremes
    send(1); send(16'hFFFF); send(32'h10000); send(32'h1FFFF);
    send(32'h3FFFF); send(32'h5FFFF); send(32'h7FFFF); send(32'h60001);
    idle(4);

    // dense sweep through all octants and fine digits, back-to-back (R6)
    for (int i = 0; i < 1024; i++) send(i * 512 + (i * 37) % 512);
    idle(2);

    // gapped random traffic (R6, R7)
    for (int i = 0; i < 200; i++) begin
      send(int'($urandom_range(FULL - 1, 0)));
      idle(i % 3);
    end

    // symmetric triples for R9 and R10
    for (int i = 0; i < 64; i++) begin
      int b;
      b = int'($urandom_range(FULL - 1, 0));
      symBase.push_back(b);
      send(b); send((b + FULL / 4) % FULL); send((b + FULL / 2) % FULL);
    end
    idle(1);
    for (int i = 0; i < 40 && expQ.size() != 0; i++) idle(1);
    idle(2);
    check(got == sent, "R6", "one output per accepted phase", got, sent);

    foreach (symBase[i]) begin
      int b, q, h;
      b = symBase[i];
      q = (b + FULL / 4) % FULL;
      h = (b + FULL / 2) % FULL;
      if (sinRes.exists(b) && sinRes.exists(q) && sinRes.exists(h)) begin
        check(sinRes[h] == -sinRes[b], "R9", "half-period sine", sinRes[h], -sinRes[b]);
        check(cosRes[h] == -cosRes[b], "R9", "half-period cosine", cosRes[h], -cosRes[b]);
        check(sinRes[q] == cosRes[b], "R10", "quarter-period sine", sinRes[q], cosRes[b]);
        check(cosRes[q] == -sinRes[b], "R10", "quarter-period cosine", cosRes[q], -sinRes[b]);
      end else begin
        check(1'b0, "R9", "missing symmetric result", 0, 1);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d outputs", got, sent);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule